// File: doc/BRIEF.md
# UART Line Status Register

This block keeps the line status byte of a UART. The receiver and the transmitter report events to it as one-cycle pulses. The CPU reads or writes it through strobes. Each status bit has its own rule for when it is set and when it is cleared. The byte is always available on `lsr_o`. Two interrupt requests come out of the block: one for receiver line errors and one for an empty transmit holding register.

The block computes the parity check itself. It uses the received character, the received parity bit and two configuration inputs. Overrun is detected from the current data-ready state. Framing and break arrive as inputs from the receiver. Every event is registered, so a pulse in cycle N shows up on `lsr_o` after the clock edge that ends cycle N. When a set event and a clearing strobe land in the same cycle, the set wins, so no error indication is lost.

Top module: `uart_line_status`

## Requirements
- R1: Data ready (bit 0) becomes 1 after a cycle with `rx_xfer_i` high. It becomes 0 after a cycle with `rbr_rd_i` high. It also becomes 0 after a cycle with `lsr_we_i` high and `lsr_wdata_i` = 0. Writing 1 leaves it unchanged. If `rx_xfer_i` is high in the same cycle as a clearing strobe, the bit becomes 1.
- R2: Overrun (bit 1) becomes 1 after a cycle in which `rx_xfer_i` is high, bit 0 is already 1, and `rbr_rd_i` is low.
- R3: Parity error (bit 2) becomes 1 after a transfer cycle under these conditions: `par_en_i` is 1, and the number of ones in `rx_data_i` plus `rx_par_bit_i` is odd when `even_par_i` = 1, or even when `even_par_i` = 0. With `par_en_i` = 0 the bit is never set.
- R4: Framing error (bit 3) becomes 1 after a transfer cycle in which `rx_stop_i` is 0.
- R5: Break (bit 4) becomes 1 after any cycle with `rx_brk_i` high.
- R6: Bits 1 to 4 become 0 after a cycle with `lsr_rd_i` high. A bit whose set event is also present in that cycle becomes 1 instead.
- R7: `rls_irq_o` is 1 exactly while any of bits 1 to 4 is 1.
- R8: Holding register empty (bit 5) becomes 1 after a cycle with `tx_xfer_i` high. It becomes 0 after a cycle with `tx_thr_load_i` high and `tx_xfer_i` low. `thre_irq_o` equals bit 5 AND `thre_ie_i`.
- R9: Shift register empty (bit 6) becomes 0 after a cycle with `tx_xfer_i` high. It becomes 1 after a cycle with `tx_idle_i` high and `tx_xfer_i` low. CPU writes do not affect it.
- R10: Bit 7 always reads 0.
- R11: After reset, `lsr_o` is 0x60 and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_xfer_i | input | 1 | Received character moved into the receive buffer |
| rx_data_i | input | DATA_W | Received character bits |
| rx_par_bit_i | input | 1 | Received parity bit |
| par_en_i | input | 1 | Parity checking enabled |
| even_par_i | input | 1 | 1 selects even parity, 0 selects odd parity |
| rx_stop_i | input | 1 | Sampled stop bit level |
| rx_brk_i | input | 1 | Break detected pulse |
| tx_thr_load_i | input | 1 | CPU loads the transmit holding register |
| tx_xfer_i | input | 1 | Holding register moved into the shift register |
| tx_idle_i | input | 1 | Shift register went idle |
| rbr_rd_i | input | 1 | CPU reads the receive buffer |
| lsr_rd_i | input | 1 | CPU reads the status byte |
| lsr_we_i | input | 1 | CPU writes the data-ready bit |
| lsr_wdata_i | input | 1 | Value written to the data-ready bit |
| thre_ie_i | input | 1 | Holding register empty interrupt enable |
| lsr_o | output | 8 | Status byte |
| rls_irq_o | output | 1 | Receiver line status interrupt |
| thre_irq_o | output | 1 | Holding register empty interrupt |

## Verification
The parity checker is swept over every combination of a 4-bit character, parity bit, parity mode and enable. This separates an inverted mode sense, a missing enable, and a dropped bit in the ones count. For data ready and overrun, the bench sweeps the prior data-ready state against every mix of transfer, buffer read and status read in one cycle. This pattern exposes a clear that wins over a set, and an overrun flagged when the old character was read in that same cycle. The transmit pair is swept over all four prior states against all eight combinations of load, transfer and idle. Together these pin down the opposite priorities of the two bits and the gating of the interrupt enable.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int LSR_W   = 8;
  localparam int ERR_N   = 4;
  localparam int B_DR    = 0;
  localparam int B_ERR0  = 1;
  localparam int B_THRE  = 5;
  localparam int B_TEMT  = 6;
  // error flag order matches lsr bits 1..4
  typedef enum int {E_OVR = 0, E_PAR = 1, E_FRM = 2, E_BRK = 3} err_idx_e;
endpackage

// File: rtl/lsr_flag.sv
module lsr_flag #(
  parameter logic RST_VAL  = 1'b0,
  parameter bit   SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  generate
    if (SET_WINS) begin : g_set_pri
      assign q_d = set_i | (q_o & ~clr_i);
    end else begin : g_clr_pri
      assign q_d = ~clr_i & (set_i | q_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/lsr_parity_chk.sv
module lsr_parity_chk #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              en_i,
  input  logic              even_i,
  output logic              err_o
);
  logic odd_ones;
  assign odd_ones = ^{data_i, par_bit_i};
  assign err_o    = en_i & (even_i ? odd_ones : ~odd_ones);
endmodule

// File: rtl/lsr_rx_flags.sv
module lsr_rx_flags
  import lsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_bit_i,
  input  logic              par_en_i,
  input  logic              even_par_i,
  input  logic              stop_i,
  input  logic              brk_i,
  input  logic              rbr_rd_i,
  input  logic              lsr_rd_i,
  input  logic              we_i,
  input  logic              wdata_i,
  output logic              dr_o,
  output logic [ERR_N-1:0]  err_o
);
  logic             par_err;
  logic [ERR_N-1:0] err_set;

  lsr_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data_i   (data_i),
    .par_bit_i(par_bit_i),
    .en_i     (par_en_i),
    .even_i   (even_par_i),
    .err_o    (par_err)
  );

  always_comb begin
    err_set        = '0;
    // old character is lost only if nobody reads it this cycle
    err_set[E_OVR] = xfer_i & dr_o & ~rbr_rd_i;
    err_set[E_PAR] = xfer_i & par_err;
    err_set[E_FRM] = xfer_i & ~stop_i;
    err_set[E_BRK] = brk_i;
  end

  lsr_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_dr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (xfer_i),
    .clr_i (rbr_rd_i | (we_i & ~wdata_i)),
    .q_o   (dr_o)
  );

  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    lsr_flag #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_err (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (err_set[i]),
      .clr_i (lsr_rd_i),
      .q_o   (err_o[i])
    );
  end
endmodule

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_load_i,
  input  logic xfer_i,
  input  logic idle_i,
  input  logic ie_i,
  output logic thre_o,
  output logic temt_o,
  output logic irq_o
);
  lsr_flag #(.RST_VAL(1'b1), .SET_WINS(1'b1)) u_thre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (xfer_i),
    .clr_i (thr_load_i),
    .q_o   (thre_o)
  );

  // a transfer refills the shift register, so it beats an idle report
  lsr_flag #(.RST_VAL(1'b1), .SET_WINS(1'b0)) u_temt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (idle_i),
    .clr_i (xfer_i),
    .q_o   (temt_o)
  );

  assign irq_o = thre_o & ie_i;
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import lsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_xfer_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_bit_i,
  input  logic              par_en_i,
  input  logic              even_par_i,
  input  logic              rx_stop_i,
  input  logic              rx_brk_i,
  input  logic              tx_thr_load_i,
  input  logic              tx_xfer_i,
  input  logic              tx_idle_i,
  input  logic              rbr_rd_i,
  input  logic              lsr_rd_i,
  input  logic              lsr_we_i,
  input  logic              lsr_wdata_i,
  input  logic              thre_ie_i,
  output logic [LSR_W-1:0]  lsr_o,
  output logic              rls_irq_o,
  output logic              thre_irq_o
);
  logic             dr;
  logic [ERR_N-1:0] err;
  logic             thre;
  logic             temt;

  lsr_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .xfer_i    (rx_xfer_i),
    .data_i    (rx_data_i),
    .par_bit_i (rx_par_bit_i),
    .par_en_i  (par_en_i),
    .even_par_i(even_par_i),
    .stop_i    (rx_stop_i),
    .brk_i     (rx_brk_i),
    .rbr_rd_i  (rbr_rd_i),
    .lsr_rd_i  (lsr_rd_i),
    .we_i      (lsr_we_i),
    .wdata_i   (lsr_wdata_i),
    .dr_o      (dr),
    .err_o     (err)
  );

  lsr_tx_flags u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_load_i(tx_thr_load_i),
    .xfer_i    (tx_xfer_i),
    .idle_i    (tx_idle_i),
    .ie_i      (thre_ie_i),
    .thre_o    (thre),
    .temt_o    (temt),
    .irq_o     (thre_irq_o)
  );

  always_comb begin
    lsr_o                        = '0;
    lsr_o[B_DR]                  = dr;
    lsr_o[B_ERR0 +: ERR_N]       = err;
    lsr_o[B_THRE]                = thre;
    lsr_o[B_TEMT]                = temt;
  end

  assign rls_irq_o = |err;
endmodule

// File: rtl/lsr_sva.sv
module lsr_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_xfer_i,
  input logic       rx_brk_i,
  input logic       rbr_rd_i,
  input logic       lsr_rd_i,
  input logic       tx_xfer_i,
  input logic [7:0] lsr_o,
  input logic       rls_irq_o
);
  AST_DR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_xfer_i |=> lsr_o[0]); // R1
  AST_DR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbr_rd_i && !rx_xfer_i) |=> !lsr_o[0]); // R1
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_xfer_i && lsr_o[0] && !rbr_rd_i) |=> lsr_o[1]); // R2
  AST_BRK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_brk_i |=> lsr_o[4]); // R5
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !rx_xfer_i && !rx_brk_i) |=> (lsr_o[4:1] == 4'b0)); // R6
  AST_RLS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rls_irq_o == (lsr_o[4:1] != 4'b0)); // R7
  AST_THRE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_xfer_i |=> lsr_o[5]); // R8
  AST_TEMT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_xfer_i |=> !lsr_o[6]); // R9
  AST_BIT7_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsr_o[7]); // R10
endmodule

bind uart_line_status lsr_sva u_lsr_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rx_xfer_i(rx_xfer_i),
  .rx_brk_i (rx_brk_i),
  .rbr_rd_i (rbr_rd_i),
  .lsr_rd_i (lsr_rd_i),
  .tx_xfer_i(tx_xfer_i),
  .lsr_o    (lsr_o),
  .rls_irq_o(rls_irq_o)
);

// File: tb/tb_uart_line_status.sv
`timescale 1ns/1ps
module tb_uart_line_status;
  localparam int DW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_xfer_i = 0, rx_par_bit_i = 0, par_en_i = 0, even_par_i = 0;
  logic rx_stop_i = 1, rx_brk_i = 0, tx_thr_load_i = 0, tx_xfer_i = 0;
  logic tx_idle_i = 0, rbr_rd_i = 0, lsr_rd_i = 0, lsr_we_i = 0;
  logic lsr_wdata_i = 0, thre_ie_i = 0;
  logic [DW-1:0] rx_data_i = '0;
  logic [7:0] lsr_o;
  logic rls_irq_o, thre_irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  uart_line_status #(.DATA_W(DW)) dut (
    .clk_i, .rst_ni, .rx_xfer_i, .rx_data_i, .rx_par_bit_i, .par_en_i,
    .even_par_i, .rx_stop_i, .rx_brk_i, .tx_thr_load_i, .tx_xfer_i,
    .tx_idle_i, .rbr_rd_i, .lsr_rd_i, .lsr_we_i, .lsr_wdata_i, .thre_ie_i,
    .lsr_o, .rls_irq_o, .thre_irq_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic rx_clear();
    rbr_rd_i = 1; lsr_rd_i = 1; step(); rbr_rd_i = 0; lsr_rd_i = 0;
  endtask

  task automatic tx_pre(input logic thre, input logic temt);
    tx_xfer_i = 1; step(); tx_xfer_i = 0;
    tx_idle_i = 1; step(); tx_idle_i = 0;
    if (!temt) begin tx_xfer_i = 1; step(); tx_xfer_i = 0; end
    if (!thre) begin tx_thr_load_i = 1; step(); tx_thr_load_i = 0; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R11 reset lsr", lsr_o, 8'h60);
    chk("R11 reset irq", {6'b0, rls_irq_o, thre_irq_o}, 8'h00);
    rst_ni = 1;
    step();

    // R3 parity sweep, R7 irq follows it
    for (int c = 0; c < (1 << (DW + 3)); c++) begin
      logic [DW-1:0] d;
      logic pb, en, ev, perr;
      int ones;
      d  = c[DW-1:0];
      pb = c[DW]; en = c[DW+1]; ev = c[DW+2];
      ones = pb;
      for (int b = 0; b < DW; b++) ones += d[b];
      perr = en && ((ones % 2 == 1) == ev);
      rx_clear();
      rx_data_i = d; rx_par_bit_i = pb; par_en_i = en; even_par_i = ev;
      rx_stop_i = 1; rx_xfer_i = 1; step(); rx_xfer_i = 0;
      chk("R3 parity", lsr_o, 8'h61 | (8'(perr) << 2));
      chk("R7 irq parity", {7'b0, rls_irq_o}, {7'b0, perr});
    end
    par_en_i = 0;

    // R1 R2 data ready / overrun sweep
    for (int c = 0; c < 16; c++) begin
      logic pre, x, rr, lr, exp_dr, exp_oe;
      pre = c[0]; x = c[1]; rr = c[2]; lr = c[3];
      rx_clear();
      if (pre) begin rx_xfer_i = 1; step(); rx_xfer_i = 0; end
      rx_xfer_i = x; rbr_rd_i = rr; lsr_rd_i = lr; step();
      rx_xfer_i = 0; rbr_rd_i = 0; lsr_rd_i = 0;
      exp_dr = x | (pre & ~rr);
      exp_oe = x & pre & ~rr;
      chk("R1 R2 dr/oe", {6'b0, lsr_o[1:0]}, {6'b0, exp_oe, exp_dr});
    end

    // R1 write path; R10 bit 7
    rx_clear();
    rx_xfer_i = 1; step(); rx_xfer_i = 0;
    lsr_we_i = 1; lsr_wdata_i = 1; step(); lsr_we_i = 0;
    chk("R1 write one no effect", lsr_o, 8'h61);
    lsr_we_i = 1; lsr_wdata_i = 0; step(); lsr_we_i = 0;
    chk("R1 write zero clears", lsr_o, 8'h60);
    lsr_we_i = 1; lsr_wdata_i = 0; rx_xfer_i = 1; step();
    lsr_we_i = 0; rx_xfer_i = 0;
    chk("R1 set beats write", lsr_o, 8'h61);

    // R4 framing, R6 set wins over read
    rx_clear();
    rx_stop_i = 0; rx_xfer_i = 1; step(); rx_xfer_i = 0; rx_stop_i = 1;
    chk("R4 framing", lsr_o, 8'h69);
    chk("R7 irq framing", {7'b0, rls_irq_o}, 8'h01);
    rbr_rd_i = 1; step(); rbr_rd_i = 0;
    chk("R6 rbr read keeps error", lsr_o, 8'h68);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk("R6 read clears framing", lsr_o, 8'h60);
    chk("R7 irq cleared", {7'b0, rls_irq_o}, 8'h00);
    rx_stop_i = 0; rx_xfer_i = 1; lsr_rd_i = 1; step();
    rx_stop_i = 1; rx_xfer_i = 0; lsr_rd_i = 0;
    chk("R6 framing set beats read", lsr_o, 8'h69);

    // R5 break
    rx_clear();
    rx_brk_i = 1; step(); rx_brk_i = 0;
    chk("R5 break", lsr_o, 8'h70);
    rx_brk_i = 1; lsr_rd_i = 1; step(); rx_brk_i = 0; lsr_rd_i = 0;
    chk("R6 break set beats read", lsr_o, 8'h70);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    chk("R6 read clears break", lsr_o, 8'h60);

    // R8 R9 transmit sweep
    for (int c = 0; c < 64; c++) begin
      logic p_thre, p_temt, ld, xf, idl, ie, e_thre, e_temt;
      p_thre = c[0]; p_temt = c[1]; ld = c[2]; xf = c[3]; idl = c[4]; ie = c[5];
      tx_pre(p_thre, p_temt);
      thre_ie_i = ie;
      tx_thr_load_i = ld; tx_xfer_i = xf; tx_idle_i = idl; step();
      tx_thr_load_i = 0; tx_xfer_i = 0; tx_idle_i = 0;
      e_thre = xf | (p_thre & ~ld);
      e_temt = ~xf & (idl | p_temt);
      chk("R8 R9 tx bits", {1'b0, lsr_o[7:5], 3'b0, thre_irq_o},
          {1'b0, 1'b0, e_temt, e_thre, 3'b0, e_thre & ie});
    end
    thre_ie_i = 0;

    // R9 write ignored, R10 bit 7
    tx_pre(1'b1, 1'b0);
    lsr_we_i = 1; lsr_wdata_i = 1; step(); lsr_we_i = 0;
    chk("R9 R10 write ignored", lsr_o, 8'h20);

    finish_run();
  end
endmodule